// File: doc/BRIEF.md
# Multiphase Receive Clock Phase Selector

This block recovers a sampling point for a received NRZ bit stream. One bit time is divided into `NPH` time quanta, and the block runs on a clock with one cycle per quantum. A free-running quantum counter counts modulo `NPH`. The block chooses which of the `NPH` equally spaced phases of the bit clock is active. That choice is the phase index. It is the quantum count at which the selected clock has its falling edge, and this falling edge is kept on the data transitions. The sampling point lies half a bit later, where the clock rises.

The controller is a two-state machine. In `ST_IDLE` the line is assumed to be between frames. The first high-to-low transition is the start of frame. It fires transition `SOF`, which snaps the phase index straight onto the quantum count of that transition and enters `ST_TRACK`. In `ST_TRACK` every data transition is timed against the selected clock with one-quantum resolution. The result is a signed error, and the decoder shifts the phase index by that error, limited to `MAX_STEP` quanta per edge. One strobe per bit marks the sampling point, and the data bit is captured on it. After `IDLE_BITS` consecutive high samples, transition `END` returns the machine to `ST_IDLE`, ready for the next hard alignment.

Top module: `rxps_phase_sel`

## Requirements
- R1: Reset clears the phase index to 0, holds `sample_stb` low and `sample_bit` high. The quantum counter reads 0 on the first clock edge after reset is released, and then counts up by one per edge, modulo `NPH`.
- R2: In `ST_IDLE` no strobe is produced and the phase index holds, for as long as `rxd` stays high.
- R3: In `ST_IDLE`, a clock edge that sees `rxd` low after it was high is the start of frame. From the next cycle, the phase index equals the quantum count seen at that edge, and the machine is in `ST_TRACK`, whatever the previous index was.
- R4: In `ST_TRACK`, the position of an edge is (quantum count − phase index) mod `NPH`. At the edge where the position equals (`NPH`−1)/2, `sample_stb` goes high for exactly one cycle and `sample_bit` takes the `rxd` value seen at that edge. This gives one strobe every `NPH` quanta while no realignment occurs.
- R5: In `ST_TRACK`, a transition of `rxd` at position d gives an error e. If d ≤ (`NPH`−1)/2 then e = d, otherwise e = d − `NPH`. The phase index moves by e from the next cycle.
- R6: The correction applied on one transition is limited to the range −`MAX_STEP`..+`MAX_STEP`.
- R7: A transition at position 0 leaves the phase index unchanged.
- R8: The phase index is unsigned binary and stays within 0..`NPH`−1. Corrections wrap modulo `NPH`, in both directions.
- R9: In `ST_TRACK`, after `IDLE_BITS` consecutive strobes that sample `rxd` high, the machine returns to `ST_IDLE` and strobes stop. The next start of frame snaps the index again with no step limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Quantum-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Received single-rail NRZ data, synchronous to `clk`, high when recessive |
| phase_idx | output | PW = $clog2(NPH) | Selected clock phase (quantum count of its falling edge) |
| sample_stb | output | 1 | One-cycle strobe at the sampling point of each bit |
| sample_bit | output | 1 | Data bit captured on the latest strobe |

## Verification
The bench builds the block with `NPH` = 25, `MAX_STEP` = 4 and `IDLE_BITS` = 6. With a step limit of 4, a transition five or more quanta off the selected clock shows the clamp in both directions. The same frame also has small corrections that pass through unchanged and corrections that wrap past 0 and past 24. The short idle count lets a frame end inside the run. A fresh start of frame can then be placed far from the old phase, which shows that hard alignment ignores the step limit.

// File: rtl/rxps_pkg.sv
package rxps_pkg;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_TRACK = 1'b1
    } rxps_state_e;

endpackage

// File: rtl/rxps_qcount.sv
module rxps_qcount #(
    parameter int NPH = 25,
    localparam int PW = $clog2(NPH)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [PW-1:0] cnt
);
    localparam logic [PW-1:0] LAST = PW'(NPH - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    // R1
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

endmodule

// File: rtl/rxps_edge.sv
module rxps_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic rxd,
    output logic edge_any,
    output logic edge_fall
);
    logic rx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rx_q <= 1'b1;
        else
            rx_q <= rxd;
    end

    assign edge_any  = rxd ^ rx_q;
    assign edge_fall = rx_q & ~rxd;

endmodule

// File: rtl/rxps_tdc.sv
module rxps_tdc #(
    parameter int NPH      = 25,
    parameter int MAX_STEP = 12,
    localparam int PW = $clog2(NPH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PW-1:0]        cnt,
    input  logic [PW-1:0]        phase,
    output logic [PW-1:0]        pos,
    output logic signed [PW:0]   err,
    output logic signed [PW:0]   step
);
    localparam logic [PW-1:0]      HALF_POS = PW'((NPH - 1) / 2);
    localparam logic [PW:0]        NPH_U    = (PW+1)'(NPH);
    localparam logic signed [PW:0] LIM      = (PW+1)'(MAX_STEP);

    logic [PW:0] diff;

    // quantum distance from the selected falling edge
    always_comb begin
        if (cnt >= phase)
            diff = {1'b0, cnt} - {1'b0, phase};
        else
            diff = {1'b0, cnt} + NPH_U - {1'b0, phase};
        pos = diff[PW-1:0];
    end

    // fold into a signed error centred on zero
    always_comb begin
        if (pos > HALF_POS)
            err = $signed({1'b0, pos}) - $signed(NPH_U);
        else
            err = $signed({1'b0, pos});
    end

    // limit the per-edge correction
    always_comb begin
        if (err > LIM)
            step = LIM;
        else if (err < -LIM)
            step = -LIM;
        else
            step = err;
    end

    // R6
    step_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err == 0) == (step == 0));

endmodule

// File: rtl/rxps_ctrl.sv
module rxps_ctrl
    import rxps_pkg::*;
#(
    parameter int NPH       = 25,
    parameter int IDLE_BITS = 10,
    localparam int PW = $clog2(NPH),
    localparam int HW = $clog2(IDLE_BITS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rxd,
    input  logic               edge_any,
    input  logic               edge_fall,
    input  logic [PW-1:0]      cnt,
    input  logic [PW-1:0]      pos,
    input  logic signed [PW:0] err,
    input  logic signed [PW:0] step,
    output logic [PW-1:0]      phase_q,
    output logic               sample_stb,
    output logic               sample_bit
);
    localparam logic [PW-1:0]        HALF_POS = PW'((NPH - 1) / 2);
    localparam logic [HW-1:0]        RUN_LAST = HW'(IDLE_BITS - 1);
    localparam logic signed [PW+1:0] NPH_S    = (PW+2)'(NPH);

    rxps_state_e state_q, state_d;
    logic [HW-1:0]        hi_run_q;
    logic                 strobe_now, end_now;
    logic signed [PW+1:0] sum;
    logic [PW-1:0]        phase_adj;

    assign strobe_now = (state_q == ST_TRACK) && (pos == HALF_POS);
    assign end_now    = strobe_now && rxd && (hi_run_q == RUN_LAST);

    // modular phase correction
    always_comb begin
        sum = $signed({2'b00, phase_q}) + $signed({step[PW], step});
        if (sum < 0)
            sum = sum + NPH_S;
        else if (sum >= NPH_S)
            sum = sum - NPH_S;
        phase_adj = sum[PW-1:0];
    end

    // next-state logic: SOF and END transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (edge_fall) state_d = ST_TRACK;
            ST_TRACK: if (end_now)   state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // registered outputs and run counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q    <= '0;
            sample_stb <= 1'b0;
            sample_bit <= 1'b1;
            hi_run_q   <= '0;
        end else begin
            sample_stb <= strobe_now;
            if (strobe_now)
                sample_bit <= rxd;
            unique case (state_q)
                ST_IDLE: begin
                    hi_run_q <= '0;
                    if (edge_fall)
                        phase_q <= cnt;
                end
                ST_TRACK: begin
                    if (edge_any)
                        phase_q <= phase_adj;
                    if (strobe_now) begin
                        if (rxd && !end_now)
                            hi_run_q <= hi_run_q + 1'b1;
                        else
                            hi_run_q <= '0;
                    end
                end
                default: hi_run_q <= '0;
            endcase
        end
    end

    // R3
    sof_snap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && edge_fall) |=> (phase_q == $past(cnt) && state_q == ST_TRACK));

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !edge_fall) |=> (!sample_stb && $stable(phase_q)));

    // R7
    zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TRACK && edge_any && err == 0) |=> $stable(phase_q));

    // R8
    phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q < PW'(NPH));

    // R4
    stb_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |=> !sample_stb);

endmodule

// File: rtl/rxps_phase_sel.sv
module rxps_phase_sel #(
    parameter int NPH       = 25,
    parameter int MAX_STEP  = 12,
    parameter int IDLE_BITS = 10,
    localparam int PW = $clog2(NPH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rxd,
    output logic [PW-1:0] phase_idx,
    output logic          sample_stb,
    output logic          sample_bit
);
    logic [PW-1:0]      cnt;
    logic [PW-1:0]      pos;
    logic signed [PW:0] err;
    logic signed [PW:0] step;
    logic               edge_any;
    logic               edge_fall;

    rxps_qcount #(.NPH(NPH)) u_qcount (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt   (cnt)
    );

    rxps_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .rxd       (rxd),
        .edge_any  (edge_any),
        .edge_fall (edge_fall)
    );

    rxps_tdc #(.NPH(NPH), .MAX_STEP(MAX_STEP)) u_tdc (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt   (cnt),
        .phase (phase_idx),
        .pos   (pos),
        .err   (err),
        .step  (step)
    );

    rxps_ctrl #(.NPH(NPH), .IDLE_BITS(IDLE_BITS)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .rxd        (rxd),
        .edge_any   (edge_any),
        .edge_fall  (edge_fall),
        .cnt        (cnt),
        .pos        (pos),
        .err        (err),
        .step       (step),
        .phase_q    (phase_idx),
        .sample_stb (sample_stb),
        .sample_bit (sample_bit)
    );

endmodule

// File: tb/rxps_phase_sel_bench.sv
`timescale 1ns/1ps
module rxps_phase_sel_bench;
    localparam int NPH   = 25;
    localparam int STEP  = 4;
    localparam int IDLEB = 6;
    localparam int HALF  = (NPH - 1) / 2;
    localparam int PW    = $clog2(NPH);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rxd = 1'b1;
    logic [PW-1:0] phase_idx;
    logic          sample_stb;
    logic          sample_bit;

    int n_total = 0;
    int n_fail  = 0;
    int eno     = 0;
    int stb_cnt = 0;
    int stb_hi  = 0;
    int last_stb_e = -1;
    int last_bit   = -1;
    int exp_p      = 0;

    always #4 clk = ~clk;

    rxps_phase_sel #(.NPH(NPH), .MAX_STEP(STEP), .IDLE_BITS(IDLEB)) u_rxps_phase_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .rxd        (rxd),
        .phase_idx  (phase_idx),
        .sample_stb (sample_stb),
        .sample_bit (sample_bit)
    );

    // edge counter and strobe monitor, settled after each rising edge
    always @(posedge clk) begin
        #1;
        if (rst_n) eno++;
        if (sample_stb) begin
            stb_cnt++;
            last_stb_e = eno;
            last_bit   = int'(sample_bit);
            if (sample_bit) stb_hi++;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_total++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int wrapn(input int v);
        return ((v % NPH) + NPH) % NPH;
    endfunction

    // drive a new level so that the edge seeing it has the given quantum count
    task automatic drive_cnt(input int c, input logic val, output int te);
        forever begin
            @(negedge clk);
            if (eno % NPH == c) begin
                rxd = val;
                break;
            end
        end
        @(negedge clk);
        te = eno;
    endtask

    // drive a new level at a position relative to the expected phase
    task automatic drive_pos(input int d, input logic val, output int te);
        drive_cnt(wrapn(d + exp_p), val, te);
    endtask

    task automatic wait_edge(input int e);
        while (eno < e) @(negedge clk);
    endtask

    function automatic int next_strobe(input int after);
        for (int e = after + 1; e < after + 2 * NPH; e++)
            if (wrapn((e - 1) - exp_p) == HALF) return e;
        return -1;
    endfunction

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 phase after reset", int'(phase_idx), 0);
        check("R1 strobe after reset", int'(sample_stb), 0);
        check("R1 bit after reset", int'(sample_bit), 1);
    endtask

    task automatic t_idle();
        int base = stb_cnt;
        repeat (60) @(negedge clk);
        check("R2 no strobes while idle", stb_cnt - base, 0);
        check("R2 phase held while idle", int'(phase_idx), 0);
    endtask

    task automatic t_sof(input int c, input string req);
        int te, base, es;
        base = stb_cnt;
        drive_cnt(c, 1'b0, te);
        exp_p = c;
        check({req, " hard sync phase"}, int'(phase_idx), c);
        es = te + HALF;
        wait_edge(es - 1);
        check("R4 no early strobe", stb_cnt - base, 0);
        wait_edge(es);
        check("R4 first strobe edge", last_stb_e, es);
        check("R4 first sampled bit", last_bit, 0);
        wait_edge(es + NPH);
        check("R4 strobe period", last_stb_e, es + NPH);
        check("R4 strobe count", stb_cnt - base, 2);
    endtask

    task automatic t_track(input int d, input logic val, input string req);
        int te, e, step, es;
        drive_pos(d, val, te);
        e = (d <= HALF) ? d : d - NPH;
        step = (e > STEP) ? STEP : ((e < -STEP) ? -STEP : e);
        exp_p = wrapn(exp_p + step);
        check({req, " phase after edge"}, int'(phase_idx), exp_p);
        es = next_strobe(te);
        wait_edge(es);
        check({req, " strobe realigned"}, last_stb_e, es);
        check({req, " sampled bit"}, last_bit, int'(val));
    endtask

    task automatic t_end();
        int base_hi, base, te;
        base_hi = stb_hi;
        t_track(5, 1'b1, "R6 clamp up before idle");
        repeat (10 * NPH) @(negedge clk);
        check("R9 high strobes before idle", stb_hi - base_hi, IDLEB);
        base = stb_cnt;
        repeat (3 * NPH) @(negedge clk);
        check("R9 strobes stop in idle", stb_cnt - base, 0);
        te = exp_p;
        t_sof(wrapn(te + HALF), "R9 unclamped resync");
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        n_total++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        t_reset();
        t_idle();
        t_sof(7, "R3 R1");
        t_track(2, 1'b1, "R5 late");
        t_track(22, 1'b0, "R5 early");
        t_track(0, 1'b1, "R7 zero offset");
        t_track(8, 1'b0, "R6 clamp late");
        t_track(17, 1'b1, "R6 clamp early");
        t_track(21, 1'b0, "R5 early max");
        t_track(21, 1'b1, "R8 wrap below zero");
        t_track(3, 1'b0, "R8 wrap above top");
        t_end();
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule